// File: doc/BRIEF.md
# Register Wakeup Scoreboard

This block sits between dispatch and issue in an out-of-order core. It keeps one readiness bit for every physical register. The index space is unified: integer registers come first and floating-point registers follow them. Alongside the bits it holds a small pool of waiting consumer instructions. Each consumer slot holds the consumer's tag, its source register indices and one operand-ready flag for each source.

There are two ways to clear a register's readiness bit. A producer can be recorded on its own, which takes no slot, or a consumer can be dispatched with a destination register. A completion broadcast sets the bit again. In the same cycle it flags every waiting operand on that register as ready and reports how many consumers it woke.

A consumer whose operands are all ready is offered on the ready stream. The ready stream is a valid/ready interface. While `rdy_valid` is high and `rdy_ready` is low, the offer does not drop, unless a squash removes the offered consumer. A handshake frees the slot.

Dispatch is also a valid/ready interface. `disp_ready` falls when every slot is occupied, and a `disp_valid` raised while `disp_ready` is low has no effect. Completion, record and squash are plain strobes with no back-pressure.

Top module: `wk_wakeup_tracker`

## Requirements
- R1: After reset every register is ready, no consumer slot is occupied, `rdy_valid` is 0 and `disp_ready` is 1.
- R2: Register index k (k < NUM_INT_REGS) is integer register k, and index NUM_INT_REGS+k is floating-point register k. Marking one of them not ready leaves the other unaffected.
- R3: A producer record (`rec_valid`/`rec_reg`), or an accepted dispatch with `disp_dst_valid`=1, clears the readiness of that register. A consumer dispatched later on that register waits. A record takes no consumer slot.
- R4: A completion (`cmp_valid`/`cmp_reg`) marks the register ready. A consumer dispatched later on that register is offered without waiting.
- R5: A waiting consumer whose last unready operand completes at clock edge k is offered on the ready stream right after edge k.
- R6: A consumer with two unready sources is not offered until both have completed.
- R7: `cmp_woken` combinationally equals the number of occupied, non-squashed slots that hold an unready operand on `cmp_reg`. It is 0 when `cmp_valid` is 0.
- R8: A consumer dispatched in the same cycle as the completion of its source register is recorded as ready.
- R9: `sq_valid` with `sq_tag` removes every occupied slot holding that tag. A removed consumer is never offered, even after its sources complete, and it is not counted in `cmp_woken`.
- R10: The ready stream offers the lowest-index ready slot. `rdy_valid` holds while `rdy_ready` is low. A handshake frees that slot.
- R11: `disp_ready` is 0 when all NUM_ENTRIES slots are occupied. A dispatch attempted in that state is ignored.
- R12: When a completion and a producer record name the same register in the same cycle, the register ends up not ready.
- R13: A source with its valid bit at 0 counts as ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch offer |
| disp_ready | output | 1 | A free consumer slot exists |
| disp_tag | input | TAG_W | Consumer tag |
| disp_src_valid | input | NUM_SRCS | Per-source valid |
| disp_src_reg | input | NUM_SRCS x REG_W | Source register indices |
| disp_dst_valid | input | 1 | Dispatched consumer writes a register |
| disp_dst_reg | input | REG_W | Destination register index |
| rec_valid | input | 1 | Record a producer without taking a slot |
| rec_reg | input | REG_W | Register being produced |
| cmp_valid | input | 1 | Completion broadcast |
| cmp_reg | input | REG_W | Completed register |
| cmp_woken | output | CNT_W | Consumers woken by this broadcast |
| sq_valid | input | 1 | Squash strobe |
| sq_tag | input | TAG_W | Tag to remove |
| rdy_valid | output | 1 | A ready consumer is offered |
| rdy_ready | input | 1 | Downstream accepts the offer |
| rdy_tag | output | TAG_W | Tag of the offered consumer |

## Verification
The bench builds the block with 8 integer and 8 floating-point registers, 4 consumer slots, 2 sources and 4-bit tags. With only four slots, the full state and the ignored dispatch that follows it come within four dispatches. A completion then wakes all four slots at once, which pushes `cmp_woken` to its widest value and drains the ready stream in strict index order. The small register space lets one test clear integer register 3 and at the same time read index 11, its floating-point counterpart.

// File: rtl/wk_pkg.sv
package wk_pkg;
  localparam int unsigned WK_DEF_INT_REGS = 32;
  localparam int unsigned WK_DEF_FP_REGS  = 32;
  localparam int unsigned WK_DEF_ENTRIES  = 16;
  localparam int unsigned WK_DEF_SRCS     = 2;
  localparam int unsigned WK_DEF_TAG_W    = 6;
endpackage

// File: rtl/wk_pick.sv
module wk_pick #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  always_comb begin
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end
  assign any = |req;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (any == (grant != '0))); // R10
endmodule

// File: rtl/wk_scoreboard.sv
module wk_scoreboard #(
  parameter int unsigned NREGS = 64,
  parameter int unsigned REG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_valid,
  input  logic [REG_W-1:0] set_reg,
  input  logic             clr0_valid,
  input  logic [REG_W-1:0] clr0_reg,
  input  logic             clr1_valid,
  input  logic [REG_W-1:0] clr1_reg,
  output logic [NREGS-1:0] bits_o
);
  // A clear beats a set on the same register: the new producer owns it.
  for (genvar g = 0; g < NREGS; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)
        bits_o[g] <= 1'b1;
      else if ((clr0_valid && clr0_reg == REG_W'(g)) ||
               (clr1_valid && clr1_reg == REG_W'(g)))
        bits_o[g] <= 1'b0;
      else if (set_valid && set_reg == REG_W'(g))
        bits_o[g] <= 1'b1;
    end
  end

  AST_SET_MARKS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    set_valid && (set_reg < NREGS) &&
    !(clr0_valid && clr0_reg == set_reg) && !(clr1_valid && clr1_reg == set_reg)
    |=> bits_o[$past(set_reg)]); // R4
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr1_valid && (clr1_reg < NREGS) |=> !bits_o[$past(clr1_reg)]); // R12
endmodule

// File: rtl/wk_entry.sv
module wk_entry #(
  parameter int unsigned NSRC  = 2,
  parameter int unsigned REG_W = 6,
  parameter int unsigned TAG_W = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       alloc,
  input  logic [TAG_W-1:0]           alloc_tag,
  input  logic [NSRC-1:0][REG_W-1:0] alloc_reg,
  input  logic [NSRC-1:0]            alloc_rdy,
  input  logic                       cmp_valid,
  input  logic [REG_W-1:0]           cmp_reg,
  input  logic                       sq_valid,
  input  logic [TAG_W-1:0]           sq_tag,
  input  logic                       issue,
  output logic                       valid_o,
  output logic [TAG_W-1:0]           tag_o,
  output logic                       ready_o,
  output logic                       wake_hit_o
);
  logic [NSRC-1:0][REG_W-1:0] src_q;
  logic [NSRC-1:0]            opr_q;
  logic [NSRC-1:0]            match;
  logic                       killed;

  assign killed = valid_o && sq_valid && (tag_o == sq_tag);

  for (genvar s = 0; s < NSRC; s++) begin : g_match
    assign match[s] = cmp_valid && !opr_q[s] && (src_q[s] == cmp_reg);
  end

  assign wake_hit_o = valid_o && !killed && (|match);
  assign ready_o    = valid_o && (&opr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      tag_o   <= '0;
      src_q   <= '0;
      opr_q   <= '0;
    end else if (alloc) begin
      valid_o <= 1'b1;
      tag_o   <= alloc_tag;
      src_q   <= alloc_reg;
      opr_q   <= alloc_rdy;
    end else if (killed || issue) begin
      valid_o <= 1'b0;
    end else begin
      opr_q <= opr_q | match;
    end
  end

  AST_KILL_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && sq_valid && (tag_o == sq_tag) |=> !valid_o); // R9
  AST_NO_ALLOC_OVER_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !valid_o); // R11
endmodule

// File: rtl/wk_wakeup_tracker.sv
module wk_wakeup_tracker
  import wk_pkg::*;
#(
  parameter int unsigned NUM_INT_REGS = WK_DEF_INT_REGS,
  parameter int unsigned NUM_FP_REGS  = WK_DEF_FP_REGS,
  parameter int unsigned NUM_ENTRIES  = WK_DEF_ENTRIES,
  parameter int unsigned NUM_SRCS     = WK_DEF_SRCS,
  parameter int unsigned TAG_W        = WK_DEF_TAG_W,
  parameter int unsigned REG_W        = $clog2(NUM_INT_REGS + NUM_FP_REGS),
  parameter int unsigned CNT_W        = $clog2(NUM_ENTRIES + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           disp_valid,
  output logic                           disp_ready,
  input  logic [TAG_W-1:0]               disp_tag,
  input  logic [NUM_SRCS-1:0]            disp_src_valid,
  input  logic [NUM_SRCS-1:0][REG_W-1:0] disp_src_reg,
  input  logic                           disp_dst_valid,
  input  logic [REG_W-1:0]               disp_dst_reg,
  input  logic                           rec_valid,
  input  logic [REG_W-1:0]               rec_reg,
  input  logic                           cmp_valid,
  input  logic [REG_W-1:0]               cmp_reg,
  output logic [CNT_W-1:0]               cmp_woken,
  input  logic                           sq_valid,
  input  logic [TAG_W-1:0]               sq_tag,
  output logic                           rdy_valid,
  input  logic                           rdy_ready,
  output logic [TAG_W-1:0]               rdy_tag
);
  localparam int unsigned NREGS = NUM_INT_REGS + NUM_FP_REGS;

  logic [NREGS-1:0]       sb_bits;
  logic [NUM_ENTRIES-1:0] ent_valid, ent_ready, ent_hit;
  logic [NUM_ENTRIES-1:0] free_gnt, rdy_gnt;
  logic [TAG_W-1:0]       ent_tag [NUM_ENTRIES];
  logic [NUM_SRCS-1:0]    src_rdy;
  logic                   disp_fire;

  assign disp_fire = disp_valid && disp_ready;

  wk_scoreboard #(.NREGS(NREGS), .REG_W(REG_W)) u_sb (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_valid  (cmp_valid),
    .set_reg    (cmp_reg),
    .clr0_valid (disp_fire && disp_dst_valid),
    .clr0_reg   (disp_dst_reg),
    .clr1_valid (rec_valid),
    .clr1_reg   (rec_reg),
    .bits_o     (sb_bits)
  );

  // Source readiness at dispatch: table bit, or a same-cycle completion.
  always_comb begin
    for (int s = 0; s < NUM_SRCS; s++) begin
      logic tbl;
      tbl = 1'b1;
      for (int r = 0; r < NREGS; r++)
        if (disp_src_reg[s] == REG_W'(r)) tbl = sb_bits[r];
      src_rdy[s] = !disp_src_valid[s] || tbl ||
                   (cmp_valid && cmp_reg == disp_src_reg[s]);
    end
  end

  wk_pick #(.N(NUM_ENTRIES)) u_free_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (~ent_valid),
    .grant (free_gnt),
    .any   (disp_ready)
  );

  wk_pick #(.N(NUM_ENTRIES)) u_rdy_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (ent_ready),
    .grant (rdy_gnt),
    .any   (rdy_valid)
  );

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
    wk_entry #(.NSRC(NUM_SRCS), .REG_W(REG_W), .TAG_W(TAG_W)) u_ent (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc      (disp_fire && free_gnt[e]),
      .alloc_tag  (disp_tag),
      .alloc_reg  (disp_src_reg),
      .alloc_rdy  (src_rdy),
      .cmp_valid  (cmp_valid),
      .cmp_reg    (cmp_reg),
      .sq_valid   (sq_valid),
      .sq_tag     (sq_tag),
      .issue      (rdy_valid && rdy_ready && rdy_gnt[e]),
      .valid_o    (ent_valid[e]),
      .tag_o      (ent_tag[e]),
      .ready_o    (ent_ready[e]),
      .wake_hit_o (ent_hit[e])
    );
  end

  always_comb begin
    rdy_tag = '0;
    for (int e = 0; e < NUM_ENTRIES; e++)
      if (rdy_gnt[e]) rdy_tag = ent_tag[e];
  end

  assign cmp_woken = CNT_W'($countones(ent_hit));

  AST_WOKEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid |-> cmp_woken == '0); // R7
  AST_RDY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_valid && !rdy_ready && !sq_valid |=> rdy_valid); // R10
  AST_FULL_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_ready && !sq_valid && !(rdy_valid && rdy_ready) |=> !disp_ready); // R11
endmodule

// File: tb/wk_wakeup_tracker_tb.sv
module wk_wakeup_tracker_tb;
  localparam int NI = 8, NF = 8, NE = 4, NS = 2, TW = 4;
  localparam int RW = 4, CW = 3;

  logic clk = 0, rst_n = 0;
  logic disp_valid = 0, disp_ready, disp_dst_valid = 0;
  logic [TW-1:0] disp_tag = '0, sq_tag = '0, rdy_tag;
  logic [NS-1:0] disp_src_valid = '0;
  logic [NS-1:0][RW-1:0] disp_src_reg = '0;
  logic [RW-1:0] disp_dst_reg = '0, rec_reg = '0, cmp_reg = '0;
  logic rec_valid = 0, cmp_valid = 0, sq_valid = 0, rdy_valid, rdy_ready = 0;
  logic [CW-1:0] cmp_woken;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wk_wakeup_tracker #(.NUM_INT_REGS(NI), .NUM_FP_REGS(NF), .NUM_ENTRIES(NE),
    .NUM_SRCS(NS), .TAG_W(TW)) u_dut (.*);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic disp(int tag, bit v0, int r0, bit v1, int r1, bit dv = 0, int dr = 0);
    disp_valid = 1; disp_tag = TW'(tag);
    disp_src_valid = {v1, v0}; disp_src_reg = {RW'(r1), RW'(r0)};
    disp_dst_valid = dv; disp_dst_reg = RW'(dr);
    tick();
    disp_valid = 0; disp_dst_valid = 0; disp_src_valid = '0;
  endtask

  task automatic rec(int r);
    rec_valid = 1; rec_reg = RW'(r); tick(); rec_valid = 0;
  endtask

  task automatic cmp(int r, int woken, string req);
    cmp_valid = 1; cmp_reg = RW'(r); #1;
    if (woken >= 0) chk(req, int'(cmp_woken), woken);
    tick(); cmp_valid = 0;
  endtask

  task automatic pop(int tag, string req);
    chk(req, int'(rdy_valid), 1);
    chk(req, int'(rdy_tag), tag);
    rdy_ready = 1; tick(); rdy_ready = 0;
  endtask

  task automatic t_reset();
    chk("R1", int'(rdy_valid), 0);
    chk("R1", int'(disp_ready), 1);
    disp(1, 1, 5, 1, 12);
    pop(1, "R1");
  endtask

  task automatic t_record();
    rec(3);
    disp(1, 1, 3, 0, 0);
    chk("R3", int'(rdy_valid), 0);
    chk("R3", int'(disp_ready), 1);
    disp(2, 1, NI + 3, 0, 0);
    pop(2, "R2");
    cmp(3, 1, "R7");
    pop(1, "R5");
    disp(3, 1, 3, 0, 0);
    pop(3, "R4");
  endtask

  task automatic t_two_ops();
    rec(4); rec(5);
    disp(4, 1, 4, 1, 5);
    cmp(4, 1, "R7");
    chk("R6", int'(rdy_valid), 0);
    cmp(5, 1, "R7");
    pop(4, "R6");
    rec(6);
    disp(5, 1, 7, 0, 6);
    pop(5, "R13");
    cmp(6, 0, "R7");
  endtask

  task automatic t_same_cycle();
    rec(2);
    cmp_valid = 1; cmp_reg = 2;
    disp(6, 1, 2, 0, 0);
    cmp_valid = 0;
    pop(6, "R8");
  endtask

  task automatic t_clear_wins();
    cmp_valid = 1; cmp_reg = 9;
    rec(9);
    cmp_valid = 0;
    disp(7, 1, 9, 0, 0);
    chk("R12", int'(rdy_valid), 0);
    cmp(9, 1, "R12");
    pop(7, "R12");
  endtask

  task automatic t_squash();
    rec(10);
    disp(8, 1, 10, 0, 0);
    disp(9, 0, 0, 1, 10);
    sq_valid = 1; sq_tag = 8;
    cmp(10, 1, "R9");
    sq_valid = 0;
    pop(9, "R9");
    chk("R9", int'(rdy_valid), 0);
    chk("R9", int'(disp_ready), 1);
  endtask

  task automatic t_full();
    rec(1);
    disp(10, 1, 1, 0, 0, 1, 12);
    disp(11, 1, 1, 0, 0);
    disp(12, 1, 1, 0, 0);
    disp(13, 1, 1, 0, 0);
    chk("R11", int'(disp_ready), 0);
    disp(14, 0, 0, 0, 0);
    chk("R11", int'(rdy_valid), 0);
    cmp(1, 4, "R7");
    chk("R10", int'(rdy_tag), 10);
    tick();
    chk("R10", int'(rdy_valid), 1);
    pop(10, "R10");
    pop(11, "R10");
    pop(12, "R10");
    pop(13, "R10");
    chk("R11", int'(rdy_valid), 0);
    disp(15, 1, 12, 0, 0);
    chk("R3", int'(rdy_valid), 0);
    cmp(12, 1, "R3");
    pop(15, "R3");
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_record();
    t_two_ops();
    t_same_cycle();
    t_clear_wins();
    t_squash();
    t_full();
    tick();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule